// File: doc/BRIEF.md
# Byte-wide register bus master

This block is a synchronous master that performs 16-bit register reads and writes on a narrow parallel bus towards a peripheral inside an FPGA. The bus has eight data lines, split here into a driven value, an output enable and a sampled input, so that the pad ring can build the bidirectional pins. It also has a select line that is active low, a direction line, a strobe, an address-latch-enable line and a busy input from the target.

A host presents one request at a time: an 8-bit register address, a 16-bit value and a write flag. The master moves the address as one byte phase marked by the address-latch-enable line. It then moves the value as two byte phases, upper byte first. Last, it raises the select line and looks at the busy input to learn whether the target took the access. If a read finds the target busy, both value bytes are fetched again. If a write finds it busy, the select line is pulsed until the target is ready. Each phase lasts a number of clocks set by a parameter.

Top module: `regbus_master`

## Requirements
- R1: A request is taken only at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the master is idle, and any change on the request inputs during an access has no effect on that access.
- R2: Every byte phase opens with one clear clock with `bus_stb` 0, `bus_cs_n` 0 and `bus_ale` 0, and with `bus_d_out` all zeros whenever `bus_d_oe` is 1. The strobe falls only at such a clock.
- R3: During the clocks before the strobe rises, `bus_ale`, `bus_d_oe` and `bus_d_out` already carry their final values for the phase. The strobe is low for 1+SETUP_CLKS clocks and then high for STB_CLKS clocks.
- R4: The first byte phase of an access carries `req_addr` with `bus_ale` 1 and the data lines driven. Every value phase has `bus_ale` 0.
- R5: `bus_dir` is 1 for a write and 0 for a read. It takes that value one clock before the first clear clock and keeps it until the master is idle again.
- R6: The value moves in two byte phases: bits 15:8 first, then bits 7:0. This holds for reads and for writes.
- R7: On a read, `bus_d_oe` is 0 from the clear clock of the first value phase until the access ends. Each value byte is taken from `bus_d_in` on the last clock of strobe high, and `rd_data` is {first byte, second byte}.
- R8: After the last value phase of a read, `bus_cs_n` goes high for CSP_CLKS clocks and `bus_busy` is sampled on the last of them. A sample of 1 repeats both value phases, with no new address phase, and `rd_data` comes from the final pair.
- R9: After the last value phase of a write, `bus_cs_n` goes high for CSP_CLKS clocks. Each time `bus_busy` is 1 on the last of those clocks, `bus_cs_n` goes low for CSP_CLKS clocks and then high for CSP_CLKS clocks again, until a sample of 0.
- R10: `done` is high for exactly one clock per access, in the first idle clock after it. `rd_data` changes only at the end of a read.
- R11: After reset and whenever idle, `bus_cs_n`, `bus_stb`, `bus_ale`, `bus_dir` and `bus_d_oe` are 1 and `bus_d_out` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | BYTE_W | Register address |
| req_wdata | input | BYTE_W*VAL_BYTES | Value to write |
| req_ready | output | 1 | Master idle, a request can be taken |
| done | output | 1 | One-clock pulse at the end of an access |
| rd_data | output | BYTE_W*VAL_BYTES | Value returned by the last read |
| bus_d_out | output | BYTE_W | Value driven on the data lines |
| bus_d_oe | output | 1 | Data line output enable |
| bus_d_in | input | BYTE_W | Value seen on the data lines |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dir | output | 1 | Direction: 1 write, 0 read |
| bus_stb | output | 1 | Strobe, a rising edge ends a byte phase |
| bus_ale | output | 1 | Marks the address phase |
| bus_busy | input | 1 | Target busy (1) or ready (0) |

## Verification
The bound checker looks at the pin-level rules on every clock. It checks the idle pattern, the content of each clear clock, that the byte and address-latch-enable are stable when the strobe rises, that the lines are never released while the address is marked, that the direction is held through an access, and the one-clock done pulse. Other behaviour depends on a reacting target and can only be shown by the directed scenarios. This covers the byte order, the read data sampled on the last strobe clock, the repeat of the value pair after a busy read, the count of select pulses after a busy write, and the phase lengths.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  // Sequencer position; the pin driver decodes the bus lines from it.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CLEAR,
    ST_SETUP,
    ST_STROBE,
    ST_CS_HIGH,
    ST_CS_LOW
  } bus_state_t;

  typedef struct packed {
    logic cs_n;
    logic dir;
    logic stb;
    logic ale;
    logic oe;
  } ctl_pins_t;

  localparam ctl_pins_t CTL_IDLE = '{cs_n: 1'b1, dir: 1'b1, stb: 1'b1, ale: 1'b1, oe: 1'b1};

endpackage

// File: rtl/regbus_phase_timer.sv
module regbus_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/regbus_sequencer.sv
module regbus_sequencer
  import regbus_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int VAL_BYTES  = 2,
  parameter int SETUP_CLKS = 2,
  parameter int STB_CLKS   = 2,
  parameter int CSP_CLKS   = 2,
  parameter int CNT_W      = 2,
  parameter int IDX_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [BYTE_W-1:0]             req_addr,
  input  logic [BYTE_W*VAL_BYTES-1:0]   req_wdata,
  input  logic                          bus_busy,
  input  logic [BYTE_W-1:0]             bus_d_in,
  input  logic                          phase_last,
  output logic                          timer_load,
  output logic [CNT_W-1:0]              timer_val,
  output bus_state_t                    state_d,
  output logic [IDX_W-1:0]              idx_d,
  output logic                          wr_d,
  output logic [BYTE_W-1:0]             byte_d,
  output logic                          req_ready,
  output logic                          done,
  output logic [BYTE_W*VAL_BYTES-1:0]   rd_data
);

  localparam int VAL_W = BYTE_W * VAL_BYTES;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VAL_BYTES);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] STB_LD   = CNT_W'(STB_CLKS - 1);
  localparam logic [CNT_W-1:0] CSP_LD   = CNT_W'(CSP_CLKS - 1);

  bus_state_t         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               wr_q;
  logic [BYTE_W-1:0]  addr_q, addr_d;
  logic [VAL_W-1:0]   wdata_q, wdata_d;
  logic [VAL_W-1:0]   rd_sh_q;
  logic [VAL_W-1:0]   rd_data_q;
  logic               done_q;
  logic               sample;
  logic               finish;

  // Next-state decision for the access sequence.
  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    wr_d       = wr_q;
    addr_d     = addr_q;
    wdata_d    = wdata_q;
    timer_load = 1'b0;
    timer_val  = '0;
    sample     = 1'b0;
    finish     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          wr_d    = req_write;
          addr_d  = req_addr;
          wdata_d = req_wdata;
          state_d = ST_START;
        end
      end
      ST_START: begin
        idx_d   = '0;
        state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        state_d    = ST_SETUP;
        timer_load = 1'b1;
        timer_val  = SETUP_LD;
      end
      ST_SETUP: begin
        if (phase_last) begin
          state_d    = ST_STROBE;
          timer_load = 1'b1;
          timer_val  = STB_LD;
        end
      end
      ST_STROBE: begin
        if (phase_last) begin
          sample = !wr_q && (idx_q != '0);
          if (idx_q == LAST_IDX) begin
            state_d    = ST_CS_HIGH;
            timer_load = 1'b1;
            timer_val  = CSP_LD;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_CLEAR;
          end
        end
      end
      ST_CS_HIGH: begin
        if (phase_last) begin
          if (!bus_busy) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else if (wr_q) begin
            state_d    = ST_CS_LOW;
            timer_load = 1'b1;
            timer_val  = CSP_LD;
          end else begin
            idx_d   = IDX_W'(1);
            state_d = ST_CLEAR;
          end
        end
      end
      ST_CS_LOW: begin
        if (phase_last) begin
          state_d    = ST_CS_HIGH;
          timer_load = 1'b1;
          timer_val  = CSP_LD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Byte carried by the next phase: address first, then value bytes from the top.
  always_comb begin
    byte_d = addr_d;
    for (int k = 1; k <= VAL_BYTES; k++) begin
      if (idx_d == IDX_W'(k)) begin
        byte_d = wdata_d[(VAL_BYTES-k)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      wr_q      <= 1'b1;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_sh_q   <= '0;
      rd_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      done_q  <= finish;
      if (sample) begin
        rd_sh_q <= (rd_sh_q << BYTE_W) | VAL_W'(bus_d_in);
      end
      if (finish && !wr_q) begin
        rd_data_q <= rd_sh_q;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign rd_data   = rd_data_q;

endmodule

// File: rtl/regbus_pin_driver.sv
module regbus_pin_driver
  import regbus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_state_t        state_d,
  input  logic [IDX_W-1:0]  idx_d,
  input  logic              wr_d,
  input  logic [BYTE_W-1:0] byte_d,
  output logic              bus_cs_n,
  output logic              bus_dir,
  output logic              bus_stb,
  output logic              bus_ale,
  output logic              bus_d_oe,
  output logic [BYTE_W-1:0] bus_d_out
);

  ctl_pins_t         ctl_nxt, ctl_q;
  logic [BYTE_W-1:0] data_nxt, data_q;
  logic              addr_ph;
  logic              drive;

  assign addr_ph = (idx_d == '0);
  assign drive   = wr_d || addr_ph;

  // Decode the pin pattern of the state about to be entered, so the
  // registered pins line up with the sequencer state.
  always_comb begin
    ctl_nxt  = CTL_IDLE;
    data_nxt = '1;
    unique case (state_d)
      ST_IDLE: begin
        ctl_nxt  = CTL_IDLE;
        data_nxt = '1;
      end
      ST_START: begin
        ctl_nxt     = CTL_IDLE;
        ctl_nxt.dir = wr_d;
        data_nxt    = '1;
      end
      ST_CLEAR: begin
        ctl_nxt.cs_n = 1'b0;
        ctl_nxt.dir  = wr_d;
        ctl_nxt.stb  = 1'b0;
        ctl_nxt.ale  = 1'b0;
        ctl_nxt.oe   = drive;
        data_nxt     = '0;
      end
      ST_SETUP, ST_STROBE: begin
        ctl_nxt.cs_n = 1'b0;
        ctl_nxt.dir  = wr_d;
        ctl_nxt.stb  = (state_d == ST_STROBE);
        ctl_nxt.ale  = addr_ph;
        ctl_nxt.oe   = drive;
        data_nxt     = drive ? byte_d : '0;
      end
      ST_CS_HIGH, ST_CS_LOW: begin
        ctl_nxt.cs_n = (state_d == ST_CS_HIGH);
        ctl_nxt.dir  = wr_d;
        ctl_nxt.stb  = 1'b1;
        ctl_nxt.ale  = 1'b0;
        ctl_nxt.oe   = wr_d;
        data_nxt     = wr_d ? byte_d : '0;
      end
      default: begin
        ctl_nxt  = CTL_IDLE;
        data_nxt = '1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_IDLE;
      data_q <= '1;
    end else begin
      ctl_q  <= ctl_nxt;
      data_q <= data_nxt;
    end
  end

  assign bus_cs_n  = ctl_q.cs_n;
  assign bus_dir   = ctl_q.dir;
  assign bus_stb   = ctl_q.stb;
  assign bus_ale   = ctl_q.ale;
  assign bus_d_oe  = ctl_q.oe;
  assign bus_d_out = data_q;

endmodule

// File: rtl/regbus_master.sv
module regbus_master
  import regbus_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int VAL_BYTES  = 2,
  parameter int SETUP_CLKS = 2,
  parameter int STB_CLKS   = 2,
  parameter int CSP_CLKS   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [BYTE_W-1:0]           req_addr,
  input  logic [BYTE_W*VAL_BYTES-1:0] req_wdata,
  output logic                        req_ready,
  output logic                        done,
  output logic [BYTE_W*VAL_BYTES-1:0] rd_data,
  output logic [BYTE_W-1:0]           bus_d_out,
  output logic                        bus_d_oe,
  input  logic [BYTE_W-1:0]           bus_d_in,
  output logic                        bus_cs_n,
  output logic                        bus_dir,
  output logic                        bus_stb,
  output logic                        bus_ale,
  input  logic                        bus_busy
);

  localparam int MAX_A   = (SETUP_CLKS > STB_CLKS) ? SETUP_CLKS : STB_CLKS;
  localparam int MAX_LEN = (MAX_A > CSP_CLKS) ? MAX_A : CSP_CLKS;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(VAL_BYTES + 1);

  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic              phase_last;
  bus_state_t        state_d;
  logic [IDX_W-1:0]  idx_d;
  logic              wr_d;
  logic [BYTE_W-1:0] byte_d;

  regbus_phase_timer #(
    .CNT_W(CNT_W)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .last     (phase_last)
  );

  regbus_sequencer #(
    .BYTE_W     (BYTE_W),
    .VAL_BYTES  (VAL_BYTES),
    .SETUP_CLKS (SETUP_CLKS),
    .STB_CLKS   (STB_CLKS),
    .CSP_CLKS   (CSP_CLKS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .bus_busy   (bus_busy),
    .bus_d_in   (bus_d_in),
    .phase_last (phase_last),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .state_d    (state_d),
    .idx_d      (idx_d),
    .wr_d       (wr_d),
    .byte_d     (byte_d),
    .req_ready  (req_ready),
    .done       (done),
    .rd_data    (rd_data)
  );

  regbus_pin_driver #(
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W)
  ) i_pins (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .idx_d     (idx_d),
    .wr_d      (wr_d),
    .byte_d    (byte_d),
    .bus_cs_n  (bus_cs_n),
    .bus_dir   (bus_dir),
    .bus_stb   (bus_stb),
    .bus_ale   (bus_ale),
    .bus_d_oe  (bus_d_oe),
    .bus_d_out (bus_d_out)
  );

endmodule

// File: rtl/regbus_checker.sv
module regbus_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic              bus_cs_n,
  input logic              bus_dir,
  input logic              bus_stb,
  input logic              bus_ale,
  input logic              bus_d_oe,
  input logic [BYTE_W-1:0] bus_d_out
);

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_cs_n && bus_stb && bus_ale && bus_dir && bus_d_oe && (bus_d_out == '1))); // R11

  AST_CLEAR_ON_STB_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_stb) |-> (!bus_cs_n && !bus_ale && (!bus_d_oe || (bus_d_out == '0)))); // R2

  AST_STB_LOW_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !bus_stb |-> !bus_cs_n); // R2

  AST_BYTE_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_stb) |-> ($stable(bus_d_out) && $stable(bus_ale) && $stable(bus_d_oe))); // R3

  AST_RELEASED_NOT_ADDR: assert property (@(posedge clk) disable iff (rst)
    !bus_d_oe |-> !bus_ale); // R7

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(bus_dir)); // R5

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R10

endmodule

bind regbus_master regbus_checker #(.BYTE_W(BYTE_W)) i_regbus_checker (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .bus_cs_n  (bus_cs_n),
  .bus_dir   (bus_dir),
  .bus_stb   (bus_stb),
  .bus_ale   (bus_ale),
  .bus_d_oe  (bus_d_oe),
  .bus_d_out (bus_d_out)
);

// File: tb/test_regbus_master.sv
module test_regbus_master;

  localparam int CLK_PERIOD = 10;
  localparam int P_SETUP    = 2;
  localparam int P_STB      = 3;
  localparam int P_CSP      = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = 8'h00;
  logic [15:0] req_wdata = 16'h0000;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic [7:0]  bus_d_out;
  logic        bus_d_oe;
  logic [7:0]  bus_d_in = 8'hEE;
  logic        bus_cs_n, bus_dir, bus_stb, bus_ale;
  logic        bus_busy;

  regbus_master #(
    .BYTE_W(8), .VAL_BYTES(2), .SETUP_CLKS(P_SETUP), .STB_CLKS(P_STB), .CSP_CLKS(P_CSP)
  ) i_regbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in),
    .bus_cs_n(bus_cs_n), .bus_dir(bus_dir), .bus_stb(bus_stb), .bus_ale(bus_ale),
    .bus_busy(bus_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  // Target model and monitor state (written only by the monitor).
  logic [7:0] log_byte [64];
  bit         log_ale  [64];
  bit         log_oe   [64];
  bit         log_dir  [64];
  int log_n = 0;
  int acc_strobes = 0, acc_vstrobes = 0;
  int run = 0, low_run = 0, csl_run = 0;
  bit run_on = 0, csl_on = 0;
  int stb_len_err = 0, setup_err = 0, clr_err = 0, csl_err = 0, dir_err = 0, dbl_done = 0;
  int cs_rises = 0, done_total = 0, post_falls = 0;
  bit p_stb = 1, p_cs = 1, p_ready = 1, p_dir = 1, p_done = 0;

  // Written only by the scenario tasks.
  logic [15:0] tgt_base = 16'h0000;
  int busy_req = 0, busy_base = 0;

  assign bus_busy = (post_falls - busy_base) < busy_req;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_stb && !p_stb) begin
        if (low_run != 1 + P_SETUP) setup_err++;
        low_run = 0;
        log_byte[log_n % 64] = bus_d_out;
        log_ale[log_n % 64]  = bus_ale;
        log_oe[log_n % 64]   = bus_d_oe;
        log_dir[log_n % 64]  = bus_dir;
        log_n++;
        acc_strobes++;
        if (!bus_ale) acc_vstrobes++;
        run = 1;
        run_on = 1;
      end else if (run_on) begin
        if (bus_stb && !bus_cs_n) run++;
        else begin
          if (run != P_STB) stb_len_err++;
          run_on = 0;
        end
      end
      if (!bus_stb && p_stb) begin
        low_run = 1;
        if (bus_cs_n || bus_ale || (bus_d_oe && bus_d_out != 8'h00)) clr_err++;
      end else if (!bus_stb) begin
        low_run++;
      end
      if (!bus_cs_n && p_cs) begin
        if (acc_strobes >= 3) post_falls++;
        if (bus_stb && p_stb) begin
          csl_run = 1;
          csl_on = 1;
        end
      end else if (!bus_cs_n && csl_on) begin
        csl_run++;
      end
      if (bus_cs_n && !p_cs) begin
        cs_rises++;
        if (csl_on) begin
          if (csl_run != P_CSP) csl_err++;
          csl_on = 0;
        end
      end
      if (!req_ready && !p_ready && bus_dir != p_dir) dir_err++;
      if (done) begin
        done_total++;
        if (p_done) dbl_done++;
        acc_strobes = 0;
        acc_vstrobes = 0;
      end
      // Read data: valid only on the last strobe-high clock.
      if (bus_stb && !bus_d_oe && run_on && run == P_STB && acc_vstrobes > 0) begin
        logic [15:0] v;
        v = tgt_base + 16'(((acc_vstrobes - 1) / 2) * 16'h0101);
        bus_d_in = ((acc_vstrobes - 1) % 2 == 0) ? v[15:8] : v[7:0];
      end else begin
        bus_d_in = 8'hEE;
      end
    end
    p_stb = bus_stb; p_cs = bus_cs_n; p_ready = req_ready; p_dir = bus_dir; p_done = done;
  end

  function automatic int err_sum();
    return stb_len_err + setup_err + clr_err + csl_err + dir_err + dbl_done;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  int s_log, s_rise, s_done, s_err;

  task automatic do_access(input bit wr, input logic [7:0] a, input logic [15:0] d);
    s_log = log_n; s_rise = cs_rises; s_done = done_total; s_err = err_sum();
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    do @(negedge clk); while (!done);
    #1;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 1);
    chk(done == 1'b0, "R10 no done after reset", 32'(done), 0);
    chk({bus_cs_n, bus_stb, bus_ale, bus_dir, bus_d_oe} == 5'b11111, "R11 idle controls",
        32'({bus_cs_n, bus_stb, bus_ale, bus_dir, bus_d_oe}), 32'h1f);
    chk(bus_d_out == 8'hFF, "R11 idle data", 32'(bus_d_out), 32'hFF);
  endtask

  task automatic t_write(input logic [7:0] a, input logic [15:0] d, input logic [15:0] keep_rd);
    busy_base = post_falls; busy_req = 0;
    do_access(1'b1, a, d);
    chk(log_n - s_log == 3, "R4 write strobe count", 32'(log_n - s_log), 3);
    chk(log_ale[s_log % 64] && log_byte[s_log % 64] == a, "R4 address phase",
        32'(log_byte[s_log % 64]), 32'(a));
    chk(!log_ale[(s_log+1) % 64] && log_byte[(s_log+1) % 64] == d[15:8], "R6 write upper byte first",
        32'(log_byte[(s_log+1) % 64]), 32'(d[15:8]));
    chk(!log_ale[(s_log+2) % 64] && log_byte[(s_log+2) % 64] == d[7:0], "R6 write lower byte second",
        32'(log_byte[(s_log+2) % 64]), 32'(d[7:0]));
    chk(log_dir[s_log % 64] && log_dir[(s_log+2) % 64], "R5 direction high for write",
        32'(log_dir[(s_log+2) % 64]), 1);
    chk(cs_rises - s_rise == 1, "R9 single select rise when ready", 32'(cs_rises - s_rise), 1);
    chk(rd_data == keep_rd, "R10 rd_data kept on write", 32'(rd_data), 32'(keep_rd));
    chk(err_sum() == s_err, "R3 phase timing and clear clocks", 32'(err_sum() - s_err), 0);
    chk(done_total - s_done == 1, "R10 one done", 32'(done_total - s_done), 1);
  endtask

  task automatic t_read(input logic [7:0] a, input logic [15:0] base, input int busy_n);
    logic [15:0] exp;
    int n_str;
    tgt_base = base;
    busy_base = post_falls; busy_req = busy_n;
    exp = base + 16'(busy_n * 16'h0101);
    n_str = 3 + 2 * busy_n;
    do_access(1'b0, a, 16'hDEAD);
    chk(rd_data == exp, "R7 R8 read data", 32'(rd_data), 32'(exp));
    chk(log_n - s_log == n_str, "R8 read strobe count", 32'(log_n - s_log), 32'(n_str));
    chk(log_ale[s_log % 64] && log_oe[s_log % 64] && log_byte[s_log % 64] == a,
        "R4 read address phase", 32'(log_byte[s_log % 64]), 32'(a));
    for (int k = 1; k < n_str; k++) begin
      chk(!log_ale[(s_log+k) % 64] && !log_oe[(s_log+k) % 64], "R7 value phase released, no address",
          32'({log_ale[(s_log+k) % 64], log_oe[(s_log+k) % 64]}), 0);
      chk(!log_dir[(s_log+k) % 64], "R5 direction low for read", 32'(log_dir[(s_log+k) % 64]), 0);
    end
    chk(cs_rises - s_rise == 1 + busy_n, "R8 select rises", 32'(cs_rises - s_rise), 32'(1 + busy_n));
    chk(err_sum() == s_err, "R2 R3 clear clocks and timing", 32'(err_sum() - s_err), 0);
    chk(bus_d_oe && bus_d_out == 8'hFF, "R11 lines back to output high", 32'(bus_d_out), 32'hFF);
  endtask

  task automatic t_write_busy(input int busy_n);
    busy_base = post_falls; busy_req = busy_n;
    do_access(1'b1, 8'h21, 16'hC3A5);
    chk(log_n - s_log == 3, "R9 no byte repeat on write", 32'(log_n - s_log), 3);
    chk(cs_rises - s_rise == 1 + busy_n, "R9 select pulses while busy", 32'(cs_rises - s_rise), 32'(1 + busy_n));
    chk(err_sum() == s_err, "R9 select pulse length", 32'(err_sum() - s_err), 0);
    busy_req = 0;
  endtask

  task automatic t_ignore();
    busy_base = post_falls; busy_req = 0;
    s_log = log_n; s_done = done_total;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h5A; req_wdata = 16'h1234;
    @(negedge clk);
    req_addr = 8'hA5; req_wdata = 16'hFFFF; req_write = 1'b0;
    do @(negedge clk); while (!done);
    req_valid = 1'b0;
    #1;
    chk(log_n - s_log == 3, "R1 one access only", 32'(log_n - s_log), 3);
    chk(log_byte[s_log % 64] == 8'h5A, "R1 address taken at accept", 32'(log_byte[s_log % 64]), 32'h5A);
    chk(log_byte[(s_log+1) % 64] == 8'h12 && log_byte[(s_log+2) % 64] == 8'h34,
        "R1 value taken at accept", 32'({log_byte[(s_log+1) % 64], log_byte[(s_log+2) % 64]}), 32'h1234);
    repeat (4) @(negedge clk);
    #1;
    chk(log_n - s_log == 3 && req_ready, "R1 no access after release", 32'(log_n - s_log), 3);
    chk(done_total - s_done == 1, "R10 single done", 32'(done_total - s_done), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    t_reset();
    t_write(8'h10, 16'hA1B2, 16'h0000);
    t_read(8'h33, 16'h5C7E, 0);
    t_write(8'h44, 16'h0F0F, 16'h5C7E);
    t_read(8'h7F, 16'h3C90, 1);
    t_write_busy(2);
    t_ignore();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule